// File: doc/BRIEF.md
# Sticky Round-Robin Kernel Slot Selector

This block decides which resident kernel slot should supply the next thread block to a dispatcher. It holds a small table of kernel slots. Each slot records whether it is occupied, whether its kernel still has blocks waiting to be dispatched, a launch identifier, and whether that launch has ever been selected. Launch, drain and retirement events arrive as slot-update inputs. When the dispatcher raises a select request, the block answers one cycle later with a valid flag and a slot index.

Selection is sticky. The slot chosen last time is chosen again for as long as it is occupied and still has blocks. Only when that slot can no longer supply work does a round-robin search run. The search starts at the slot after the last chosen one and wraps once around the table. The first time a launch is picked, the block emits a one-cycle start report carrying the launch identifier and the free-running cycle count. Retiring an occupied slot empties it and emits a one-cycle end report in the same form.

Top module: `kernel_slot_selector`

## Requirements
- R1: After reset all slots are empty, and every output is zero until the first update or request takes effect. The remembered last slot is NUM_SLOTS-1, so the first search begins at slot 0.
- R2: A slot is eligible when it is occupied and has blocks left. If the last chosen slot is eligible, a request returns that same slot, whatever the state of the other slots.
- R3: If the last chosen slot is not eligible, the request returns the first eligible slot in the order last+1, last+2, and so on, counted modulo NUM_SLOTS. That slot becomes the new last chosen slot.
- R4: If no slot is eligible, sel_valid stays low, sel_slot reads 0, and the last chosen slot is unchanged.
- R5: The first selection of a launch raises start_pulse for one cycle. It carries the slot's launch identifier and the cycle count of the request cycle. Later selections of the same launch raise no pulse. While start_pulse is low, start_id and start_cycle read 0.
- R6: Loading a slot makes it occupied with blocks left and a new identifier. It clears the slot's "already started" mark, so the next selection of that slot reports a start again.
- R7: Retiring an occupied slot empties it, so it is no longer selectable. It raises end_pulse for one cycle with the slot's identifier and the cycle count of the retire cycle. Retiring an empty slot has no effect and raises no pulse. While end_pulse is low, end_id and end_cycle read 0.
- R8: A drain clears a slot's blocks-left flag. The slot stays occupied but is no longer chosen.
- R9: All outputs are registered: they appear one cycle after the request or retire. A decision uses the table as it stood before that clock edge; updates on the same edge apply to later requests. A load and a retire of the same slot in the same cycle act as a load alone.
- R10: A cycle without a request produces no selection and no start pulse, and leaves the last chosen slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_req | input | 1 | Load a new launch into load_slot |
| load_slot | input | SLOT_W | Slot written by a load |
| load_id | input | ID_W | Launch identifier for the load |
| drain_req | input | 1 | Clear the blocks-left flag of drain_slot |
| drain_slot | input | SLOT_W | Slot drained |
| retire_req | input | 1 | Retire the kernel in retire_slot |
| retire_slot | input | SLOT_W | Slot retired |
| sel_req | input | 1 | Dispatcher asks for a slot |
| sel_valid | output | 1 | A slot was chosen |
| sel_slot | output | SLOT_W | Chosen slot, 0 when none |
| start_pulse | output | 1 | First selection of a launch |
| start_id | output | ID_W | Identifier of the starting launch |
| start_cycle | output | CYC_W | Cycle count of the first selection |
| end_pulse | output | 1 | An occupied slot was retired |
| end_id | output | ID_W | Identifier of the retired launch |
| end_cycle | output | CYC_W | Cycle count of the retirement |

## Verification
The hardest case to reach is a search whose outcome depends on both the remembered last slot and the exact pattern of eligible slots. That memory cannot be set from the ports; it only forms through earlier selections. The stimulus gets there from a fresh reset in each case. It loads only the slot meant to become the last one and selects it, then loads the other slots and drains the ones outside the chosen pattern. A single request then probes the decision. This runs for every last slot and every eligibility pattern of a five-slot table, a size that is not a power of two, so the wrap-around arithmetic is exercised. Reloading the sticky slot and draining it in the same cycle as a request cover the start-mark and edge-ordering corners.

// File: rtl/ksel_pkg.sv
package ksel_pkg;

   typedef enum logic [0:0] {
      KSEL_SEARCH_ROTATE = 1'b0,
      KSEL_SEARCH_SCAN   = 1'b1
   } ksel_search_e;

   function automatic int ksel_wrap_next(input int cur, input int n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/ksel_cycle_counter.sv
module ksel_cycle_counter #(
   parameter int CYC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CYC_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/ksel_slot_table.sv
module ksel_slot_table #(
   parameter int NUM_SLOTS = 4,
   parameter int ID_W      = 8,
   parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load_en,
   input  logic [SLOT_W-1:0]                   load_slot,
   input  logic [ID_W-1:0]                     load_id,
   input  logic                                drain_en,
   input  logic [SLOT_W-1:0]                   drain_slot,
   input  logic                                retire_en,
   input  logic [SLOT_W-1:0]                   retire_slot,
   input  logic                                mark_en,
   input  logic [SLOT_W-1:0]                   mark_slot,
   output logic [NUM_SLOTS-1:0]                slot_valid,
   output logic [NUM_SLOTS-1:0]                slot_more,
   output logic [NUM_SLOTS-1:0]                slot_started,
   output logic [NUM_SLOTS-1:0][ID_W-1:0]      slot_id
);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam logic [SLOT_W-1:0] IDX = SLOT_W'(s);
      logic hit_load, hit_retire, hit_drain, hit_mark;

      assign hit_load   = load_en   && (load_slot   == IDX);
      assign hit_retire = retire_en && (retire_slot == IDX);
      assign hit_drain  = drain_en  && (drain_slot  == IDX);
      assign hit_mark   = mark_en   && (mark_slot   == IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_valid[s]   <= 1'b0;
            slot_more[s]    <= 1'b0;
            slot_started[s] <= 1'b0;
            slot_id[s]      <= '0;
         end else if (hit_load) begin
            slot_valid[s]   <= 1'b1;
            slot_more[s]    <= 1'b1;
            slot_started[s] <= 1'b0;
            slot_id[s]      <= load_id;
         end else if (hit_retire) begin
            slot_valid[s]   <= 1'b0;
            slot_more[s]    <= 1'b0;
            slot_started[s] <= 1'b0;
         end else begin
            if (hit_drain) begin
               slot_more[s] <= 1'b0;
            end
            if (hit_mark) begin
               slot_started[s] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ksel_rr_pick.sv
module ksel_rr_pick
   import ksel_pkg::*;
#(
   parameter int           NUM_SLOTS = 4,
   parameter int           SLOT_W    = $clog2(NUM_SLOTS),
   parameter ksel_search_e STYLE     = KSEL_SEARCH_ROTATE
) (
   input  logic [NUM_SLOTS-1:0] elig,
   input  logic [SLOT_W-1:0]    last,
   output logic                 found,
   output logic [SLOT_W-1:0]    pick
);

   logic [SLOT_W-1:0] origin;

   always_comb begin
      origin = SLOT_W'(ksel_wrap_next(int'(last), NUM_SLOTS));
   end

   if (STYLE == KSEL_SEARCH_ROTATE) begin : g_rotate
      logic [2*NUM_SLOTS-1:0] doubled;
      logic [2*NUM_SLOTS-1:0] shifted;
      logic [NUM_SLOTS-1:0]   window;

      always_comb begin
         int offset;
         int pos;
         doubled = {elig, elig};
         shifted = doubled >> origin;
         window  = shifted[NUM_SLOTS-1:0];
         found   = 1'b0;
         offset  = 0;
         for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (window[k]) begin
               found  = 1'b1;
               offset = k;
            end
         end
         pos = int'(origin) + offset;
         if (pos >= NUM_SLOTS) begin
            pos = pos - NUM_SLOTS;
         end
         pick = found ? SLOT_W'(pos) : '0;
      end
   end else begin : g_scan
      always_comb begin
         int pos;
         found = 1'b0;
         pick  = '0;
         pos   = int'(origin);
         for (int k = 0; k < NUM_SLOTS; k++) begin
            if (!found && elig[pos]) begin
               found = 1'b1;
               pick  = SLOT_W'(pos);
            end
            pos = ksel_wrap_next(pos, NUM_SLOTS);
         end
      end
   end

endmodule

// File: rtl/kernel_slot_selector.sv
module kernel_slot_selector
   import ksel_pkg::*;
#(
   parameter int           NUM_SLOTS = 4,
   parameter int           ID_W      = 8,
   parameter int           CYC_W     = 32,
   parameter ksel_search_e SEARCH    = KSEL_SEARCH_ROTATE,
   parameter int           SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   input  logic [SLOT_W-1:0] load_slot,
   input  logic [ID_W-1:0]   load_id,
   input  logic              drain_req,
   input  logic [SLOT_W-1:0] drain_slot,
   input  logic              retire_req,
   input  logic [SLOT_W-1:0] retire_slot,
   input  logic              sel_req,
   output logic              sel_valid,
   output logic [SLOT_W-1:0] sel_slot,
   output logic              start_pulse,
   output logic [ID_W-1:0]   start_id,
   output logic [CYC_W-1:0]  start_cycle,
   output logic              end_pulse,
   output logic [ID_W-1:0]   end_id,
   output logic [CYC_W-1:0]  end_cycle
);

   localparam logic [SLOT_W-1:0] LAST_RESET = SLOT_W'(NUM_SLOTS - 1);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("kernel_slot_selector: NUM_SLOTS must be at least 2");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("kernel_slot_selector: ID_W must be at least 1");
   end
   if (CYC_W < 2) begin : g_bad_cyc
      $error("kernel_slot_selector: CYC_W must be at least 2");
   end
   if (SLOT_W != $clog2(NUM_SLOTS)) begin : g_bad_slotw
      $error("kernel_slot_selector: SLOT_W must equal clog2(NUM_SLOTS)");
   end

   logic [CYC_W-1:0]               cyc_now;
   logic [NUM_SLOTS-1:0]           slot_valid;
   logic [NUM_SLOTS-1:0]           slot_more;
   logic [NUM_SLOTS-1:0]           slot_started;
   logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id;
   logic [NUM_SLOTS-1:0]           elig;
   logic [SLOT_W-1:0]              last_q;
   logic                           search_found;
   logic [SLOT_W-1:0]              search_pick;
   logic                           last_ok;
   logic                           fire;
   logic [SLOT_W-1:0]              choice;
   logic                           first_sel;
   logic [ID_W-1:0]                choice_id;
   logic                           retire_hit;
   logic [ID_W-1:0]                retire_id;

   ksel_cycle_counter #(
      .CYC_W (CYC_W)
   ) cyc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cyc_now)
   );

   ksel_slot_table #(
      .NUM_SLOTS (NUM_SLOTS),
      .ID_W      (ID_W),
      .SLOT_W    (SLOT_W)
   ) table_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en      (load_req),
      .load_slot    (load_slot),
      .load_id      (load_id),
      .drain_en     (drain_req),
      .drain_slot   (drain_slot),
      .retire_en    (retire_req),
      .retire_slot  (retire_slot),
      .mark_en      (first_sel),
      .mark_slot    (choice),
      .slot_valid   (slot_valid),
      .slot_more    (slot_more),
      .slot_started (slot_started),
      .slot_id      (slot_id)
   );

   assign elig = slot_valid & slot_more;

   ksel_rr_pick #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W),
      .STYLE     (SEARCH)
   ) pick_i (
      .elig  (elig),
      .last  (last_q),
      .found (search_found),
      .pick  (search_pick)
   );

   // Sticky choice first; the search only matters when the last slot is spent.
   always_comb begin
      last_ok   = elig[last_q];
      choice    = last_ok ? last_q : search_pick;
      fire      = sel_req && (last_ok || search_found);
      first_sel = fire && !slot_started[choice];
      choice_id = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (choice == SLOT_W'(s)) begin
            choice_id = slot_id[s];
         end
      end
   end

   // A retire counts only on an occupied slot not being reloaded in the same cycle.
   always_comb begin
      retire_hit = 1'b0;
      retire_id  = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (retire_slot == SLOT_W'(s)) begin
            retire_hit = retire_req && slot_valid[s] &&
                         !(load_req && (load_slot == retire_slot));
            retire_id  = slot_id[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= LAST_RESET;
      end else if (fire) begin
         last_q <= choice;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid   <= 1'b0;
         sel_slot    <= '0;
         start_pulse <= 1'b0;
         start_id    <= '0;
         start_cycle <= '0;
         end_pulse   <= 1'b0;
         end_id      <= '0;
         end_cycle   <= '0;
      end else begin
         sel_valid   <= fire;
         sel_slot    <= fire ? choice : '0;
         start_pulse <= first_sel;
         start_id    <= first_sel ? choice_id : '0;
         start_cycle <= first_sel ? cyc_now : '0;
         end_pulse   <= retire_hit;
         end_id      <= retire_hit ? retire_id : '0;
         end_cycle   <= retire_hit ? cyc_now : '0;
      end
   end

endmodule

// File: rtl/kernel_slot_selector_chk.sv
module kernel_slot_selector_chk #(
   parameter int NUM_SLOTS = 4,
   parameter int ID_W      = 8,
   parameter int CYC_W     = 32,
   parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sel_req,
   input logic                 retire_req,
   input logic [SLOT_W-1:0]    retire_slot,
   input logic                 sel_valid,
   input logic [SLOT_W-1:0]    sel_slot,
   input logic                 start_pulse,
   input logic [CYC_W-1:0]     start_cycle,
   input logic                 end_pulse,
   input logic [NUM_SLOTS-1:0] elig,
   input logic [NUM_SLOTS-1:0] slot_valid,
   input logic [SLOT_W-1:0]    last_q,
   input logic [CYC_W-1:0]     cyc_now
);

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_req && elig[last_q]) |=> (sel_valid && sel_slot == $past(last_q)));

   assert_pick_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> ((($past(elig) >> sel_slot) & NUM_SLOTS'(1)) != '0));

   assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_req && elig == '0) |=> (!sel_valid && last_q == $past(last_q)));

   assert_start_with_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> sel_valid);

   assert_start_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (start_cycle == $past(cyc_now)));

   assert_retire_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_req && ((slot_valid >> retire_slot) & NUM_SLOTS'(1)) == '0) |=> !end_pulse);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_req |=> (!sel_valid && !start_pulse && last_q == $past(last_q)));

endmodule

bind kernel_slot_selector kernel_slot_selector_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ID_W      (ID_W),
   .CYC_W     (CYC_W),
   .SLOT_W    (SLOT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_req     (sel_req),
   .retire_req  (retire_req),
   .retire_slot (retire_slot),
   .sel_valid   (sel_valid),
   .sel_slot    (sel_slot),
   .start_pulse (start_pulse),
   .start_cycle (start_cycle),
   .end_pulse   (end_pulse),
   .elig        (elig),
   .slot_valid  (slot_valid),
   .last_q      (last_q),
   .cyc_now     (cyc_now)
);

// File: tb/kernel_slot_selector_tb_top.sv
`timescale 1ns/100ps
module kernel_slot_selector_tb_top;

   localparam int N  = 5;
   localparam int IW = 8;
   localparam int CW = 32;
   localparam int SW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_req = 1'b0;
   logic [SW-1:0] load_slot = '0;
   logic [IW-1:0] load_id = '0;
   logic          drain_req = 1'b0;
   logic [SW-1:0] drain_slot = '0;
   logic          retire_req = 1'b0;
   logic [SW-1:0] retire_slot = '0;
   logic          sel_req = 1'b0;
   logic          sel_valid;
   logic [SW-1:0] sel_slot;
   logic          start_pulse;
   logic [IW-1:0] start_id;
   logic [CW-1:0] start_cycle;
   logic          end_pulse;
   logic [IW-1:0] end_id;
   logic [CW-1:0] end_cycle;

   always #2.5 clk = ~clk;

   kernel_slot_selector #(
      .NUM_SLOTS (N),
      .ID_W      (IW),
      .CYC_W     (CW)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_req    (load_req),
      .load_slot   (load_slot),
      .load_id     (load_id),
      .drain_req   (drain_req),
      .drain_slot  (drain_slot),
      .retire_req  (retire_req),
      .retire_slot (retire_slot),
      .sel_req     (sel_req),
      .sel_valid   (sel_valid),
      .sel_slot    (sel_slot),
      .start_pulse (start_pulse),
      .start_id    (start_id),
      .start_cycle (start_cycle),
      .end_pulse   (end_pulse),
      .end_id      (end_id),
      .end_cycle   (end_cycle)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Reference cycle count: edges seen since reset release.
   longint bcyc;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) bcyc <= 0;
      else        bcyc <= bcyc + 1;
   end

   bit m_valid[N];
   bit m_more[N];
   bit m_started[N];
   int m_id[N];
   int m_last;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_more[i] = 0; m_started[i] = 0; m_id[i] = 0;
      end
      m_last = N - 1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      load_req = 0; drain_req = 0; retire_req = 0; sel_req = 0;
      repeat (2) @(negedge clk);
      model_reset();
      chk("R1", "sel_valid in reset", sel_valid, 0);
      chk("R1", "start_pulse in reset", start_pulse, 0);
      chk("R1", "end_pulse in reset", end_pulse, 0);
      chk("R1", "sel_slot in reset", sel_slot, 0);
      rst_n = 1'b1;
   endtask

   // One cycle: drive at a falling edge, sample at the next falling edge.
   task automatic step(input bit ld, input int ls, input int lid,
                       input bit dr, input int ds,
                       input bit rt, input int rs,
                       input bit rq, input string tag);
      bit     e_fire, e_first, e_end;
      int     e_idx, p;
      longint snap;
      load_req = ld;    load_slot = SW'(ls);    load_id = IW'(lid);
      drain_req = dr;   drain_slot = SW'(ds);
      retire_req = rt;  retire_slot = SW'(rs);
      sel_req = rq;
      snap = bcyc;
      e_fire = 0; e_idx = 0;
      if (rq) begin
         if (m_valid[m_last] && m_more[m_last]) begin
            e_fire = 1; e_idx = m_last;
         end else begin
            for (int i = 0; i < N; i++) begin
               p = (m_last + 1 + i) % N;
               if (!e_fire && m_valid[p] && m_more[p]) begin
                  e_fire = 1; e_idx = p;
               end
            end
         end
      end
      e_first = e_fire && !m_started[e_idx];
      e_end = rt && m_valid[rs] && !(ld && ls == rs);
      @(posedge clk);
      @(negedge clk);
      chk(tag, "sel_valid", sel_valid, e_fire);
      chk(tag, "sel_slot", sel_slot, e_fire ? e_idx : 0);
      chk(tag, "start_pulse", start_pulse, e_first);
      chk(tag, "start_id", start_id, e_first ? m_id[e_idx] : 0);
      chk(tag, "start_cycle", start_cycle, e_first ? snap : 0);
      chk(tag, "end_pulse", end_pulse, e_end);
      chk(tag, "end_id", end_id, e_end ? m_id[rs] : 0);
      chk(tag, "end_cycle", end_cycle, e_end ? snap : 0);
      if (e_fire) m_last = e_idx;
      for (int i = 0; i < N; i++) begin
         if (ld && ls == i) begin
            m_valid[i] = 1; m_more[i] = 1; m_started[i] = 0; m_id[i] = lid;
         end else if (rt && rs == i) begin
            m_valid[i] = 0; m_more[i] = 0; m_started[i] = 0;
         end else begin
            if (dr && ds == i) m_more[i] = 0;
            if (e_first && e_idx == i) m_started[i] = 1;
         end
      end
      load_req = 0; drain_req = 0; retire_req = 0; sel_req = 0;
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic load(input int s, input int id, input string tag);
      step(1, s, id, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic drain(input int s, input string tag);
      step(0, 0, 0, 1, s, 0, 0, 0, tag);
   endtask
   task automatic retire(input int s, input string tag);
      step(0, 0, 0, 0, 0, 1, s, 0, tag);
   endtask
   task automatic req(input string tag);
      step(0, 0, 0, 0, 0, 0, 0, 1, tag);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      idle("R1");
      // R1: first search starts at slot 0 although slot 2 was loaded first
      load(2, 8'h22, "R1");
      load(0, 8'h10, "R1");
      req("R1");
      // R2 / R5: sticky, no second start report
      req("R2");
      req("R5");
      // R8 then R3: drained slot 0 is skipped, search from 1 finds 2
      drain(0, "R8");
      req("R3");
      // R6: reload the sticky slot, start reported again with the new id
      load(2, 8'h55, "R6");
      req("R6");
      // R10: no request leaves everything quiet
      load(4, 8'h44, "R10");
      idle("R10");
      idle("R10");
      // R9: drain in the same cycle as the request still returns the old choice
      step(0, 0, 0, 1, 2, 0, 0, 1, "R9");
      req("R9");
      // R7: retire occupied slot reports end, retiring empty slot does not
      retire(4, "R7");
      retire(4, "R7");
      req("R4");
      req("R4");
      load(1, 8'h61, "R4");
      req("R4");
      // R9: load and retire of one slot in the same cycle act as a load
      step(1, 1, 8'h78, 0, 0, 1, 1, 0, "R9");
      req("R9");
      retire(3, "R7");
      // R2/R3/R4 sweep: every last slot against every eligibility pattern
      for (int last = 0; last < N; last++) begin
         for (int mask = 0; mask < (1 << N); mask++) begin
            do_reset();
            load(last, last * 16 + 1, "R3");
            req("R3");
            for (int s = 0; s < N; s++) begin
               if (s != last) load(s, (mask + s) & 8'hff, "R6");
            end
            for (int s = 0; s < N; s++) begin
               if (!mask[s]) drain(s, "R8");
            end
            if (mask[last])   req("R2");
            else if (mask == 0) req("R4");
            else              req("R3");
         end
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule